// File: doc/BRIEF.md
# Multicycle Packed-Decimal Processor Core

A small sequential processor that runs one instruction at a time. Each instruction goes through a fixed set of control steps: fetch, decode, address fetch, operand fetch, execute and write-back. Only the steps that the instruction needs are visited, and the next instruction is not fetched until the current one has finished. The core has four 8-bit registers, each holding two packed decimal digits, and one decimal carry/borrow flag. The instruction set has six operations: load, store, an unconditional jump, a jump taken only on carry, decimal add and decimal subtract.

The core reaches memory through one synchronous port with byte-wide data and a 16-bit address. A read is requested by holding `mem_rd` high for one cycle. The memory must return the byte on `mem_rdata` in the cycle that follows. A write is one cycle with `mem_wr` high. This port has no valid/ready handshake and applies no back-pressure: latency is fixed at one cycle, and the sequencer always spends a wait step on every read. A memory that needs more time is not supported on this port.

Instruction byte layout: opcode in bits [7:5], destination register in [3:2], source register in [1:0], and bit 4 ignored. Opcodes are: 0 load, 1 store, 2 jump, 3 jump-on-carry, 4 add, 5 subtract, 6 and 7 unused. Load, store and both jumps are followed by two address bytes, high byte first.

Top module: `bcd_cpu`

## Requirements
- R1: Reset sets the program counter to 0x0000 and clears all registers and the flag. `mem_wr` stays low during reset. In the first cycle after reset is released, the core fetches from address 0x0000 (`mem_rd` high).
- R2: The opcode is bits [7:5], the destination index is [3:2] and the source index is [1:0]. The two address bytes after a memory or jump opcode form a 16-bit address, high byte first.
- R3: Load (opcode 0) writes the byte read from the given address into the destination register.
- R4: Store (opcode 1) writes the source register to the given address with a single-cycle `mem_wr` pulse. `mem_rd` and `mem_wr` are never high together.
- R5: Add (opcode 4) sets dst to the two-digit decimal sum dst+src with per-digit correction. The flag is set exactly when the sum is 100 or more.
- R6: Subtract (opcode 5) sets dst to (dst-src) mod 100 in decimal. The flag is set exactly when src is greater than dst.
- R7: Jump (opcode 2) always loads the program counter with the 16-bit address, including addresses above 0x7FFF.
- R8: Jump-on-carry (opcode 3) is taken only when the flag is set. Otherwise execution continues after its three bytes. Only add and subtract change the flag.
- R9: Opcodes 6 and 7 advance the program counter by one and change no register or flag.
- R10: Instruction lengths are fixed at 3 cycles for unused opcodes, 5 for add and subtract, 8 for store and the jumps, and 10 for load, and instructions never overlap. A store's write pulse falls in its eighth cycle.
- R11: Each read is a one-cycle `mem_rd` pulse, and the data is taken from `mem_rdata` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request, data expected next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The hardest thing to reach from the ports is the link between the decimal flag and a later jump-on-carry. The flag is never visible directly, and a store sits between the arithmetic and the jump. Each stimulus program loads two random or corner-case decimal operands, does the arithmetic, stores the result, and then uses jump-on-carry to decide whether a marker byte gets written. Memory contents therefore reveal the flag, and the test also shows that the store in between left the flag alone. Cycle-exact timing is checked by recording the cycle of each write pulse relative to the release of reset.

// File: rtl/bcdcpu_pkg.sv
package bcdcpu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_JMP   = 3'd2,
    OP_JC    = 3'd3,
    OP_ADD   = 3'd4,
    OP_SUB   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FWAIT,
    ST_DECODE,
    ST_AHI,
    ST_AHIW,
    ST_ALO,
    ST_ALOW,
    ST_OPRD,
    ST_OPWAIT,
    ST_EXEC,
    ST_WBACK
  } step_e;

endpackage

// File: rtl/bcd_alu.sv
module bcd_alu #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         flag
);

  logic       cy;
  logic [4:0] t;

  // ripple through the digits, lowest first
  always_comb begin
    cy = 1'b0;
    t  = '0;
    y  = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (!sub) begin
        t = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, cy};
        if (t > 5'd9) begin
          y[4*i +: 4] = t[3:0] + 4'd6;
          cy = 1'b1;
        end else begin
          y[4*i +: 4] = t[3:0];
          cy = 1'b0;
        end
      end else begin
        t = {1'b0, a[4*i +: 4]} - {1'b0, b[4*i +: 4]} - {4'b0, cy};
        if (t[4]) begin
          y[4*i +: 4] = t[3:0] - 4'd6;
          cy = 1'b1;
        end else begin
          y[4*i +: 4] = t[3:0];
          cy = 1'b0;
        end
      end
    end
    flag = cy;
  end

endmodule

// File: rtl/bcd_regfile.sv
module bcd_regfile #(
  parameter int NREG = 4,
  parameter int W    = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [W-1:0]     rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [W-1:0]     rdata_b
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                regs[g] <= '0;
      else if (we && waddr == IDX_W'(g))         regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcdcpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              carry_q,
  output step_e             step,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr
);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ea;
  opcode_e           op;

  assign op = opcode_e'(ir[7:5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= ST_FETCH;
      pc   <= '0;
      ir   <= '0;
      ea   <= '0;
    end else begin
      unique case (step)
        ST_FETCH:  step <= ST_FWAIT;
        ST_FWAIT: begin
          ir   <= mem_rdata;
          pc   <= pc + 1'b1;
          step <= ST_DECODE;
        end
        ST_DECODE: begin
          unique case (op)
            OP_LOAD, OP_STORE, OP_JMP, OP_JC: step <= ST_AHI;
            OP_ADD, OP_SUB:                   step <= ST_EXEC;
            default:                          step <= ST_FETCH;
          endcase
        end
        ST_AHI:    step <= ST_AHIW;
        ST_AHIW: begin
          ea   <= {ea[ADDR_W-DATA_W-1:0], mem_rdata};
          pc   <= pc + 1'b1;
          step <= ST_ALO;
        end
        ST_ALO:    step <= ST_ALOW;
        ST_ALOW: begin
          ea   <= {ea[ADDR_W-DATA_W-1:0], mem_rdata};
          pc   <= pc + 1'b1;
          step <= (op == OP_LOAD) ? ST_OPRD : ST_EXEC;
        end
        ST_OPRD:   step <= ST_OPWAIT;
        ST_OPWAIT: step <= ST_WBACK;
        ST_EXEC: begin
          if (op == OP_JMP || (op == OP_JC && carry_q)) pc <= ea;
          step <= (op == OP_ADD || op == OP_SUB) ? ST_WBACK : ST_FETCH;
        end
        ST_WBACK:  step <= ST_FETCH;
        default:   step <= ST_FETCH;
      endcase
    end
  end

  assign mem_rd   = (step == ST_FETCH) || (step == ST_AHI) ||
                    (step == ST_ALO)   || (step == ST_OPRD);
  assign mem_wr   = (step == ST_EXEC) && (op == OP_STORE);
  assign mem_addr = (step == ST_OPRD || step == ST_EXEC) ? ea : pc;

  AST_RW_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R4
  AST_WR_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr); // R4
  AST_WR_PLACE:   assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(step) == ST_ALOW); // R10
  AST_RD_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd); // R11
  AST_RSV_PC:     assert property (@(posedge clk) disable iff (!rst_n)
                    (step == ST_DECODE && ir[7:6] == 2'b11) |=> (step == ST_FETCH && $stable(pc))); // R9

endmodule

// File: rtl/bcd_cpu.sv
module bcd_cpu
  import bcdcpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int NREG   = 4;
  localparam int DIGITS = DATA_W / 4;

  step_e             step;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] ra, rb, alu_y, mdr;
  logic              alu_flag, carry_q, is_alu;
  opcode_e           op;
  logic              ir_unused;

  assign op        = opcode_e'(ir[7:5]);
  assign is_alu    = (op == OP_ADD) || (op == OP_SUB);
  assign ir_unused = ir[4];

  bcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .carry_q(carry_q),
    .step(step), .ir(ir), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  bcd_regfile #(.NREG(NREG), .W(DATA_W)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .we(step == ST_WBACK), .waddr(ir[3:2]), .wdata(mdr),
    .raddr_a(ir[3:2]), .rdata_a(ra),
    .raddr_b(ir[1:0]), .rdata_b(rb)
  );

  bcd_alu #(.DIGITS(DIGITS)) alu_i (
    .a(ra), .b(rb), .sub(op == OP_SUB), .y(alu_y), .flag(alu_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdr     <= '0;
      carry_q <= 1'b0;
    end else if (step == ST_OPWAIT) begin
      mdr <= mem_rdata;
    end else if (step == ST_EXEC && is_alu) begin
      mdr     <= alu_y;
      carry_q <= alu_flag;
    end
  end

  assign mem_wdata = rb;

  function automatic logic all_bcd(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  AST_ALU_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
                    (step == ST_EXEC && is_alu && all_bcd(ra) && all_bcd(rb)) |=> all_bcd(mdr)); // R5
  AST_FLAG_SRC:   assert property (@(posedge clk) disable iff (!rst_n)
                    !$stable(carry_q) |-> ($past(step) == ST_EXEC && $past(is_alu))); // R8
  AST_LOAD_PATH:  assert property (@(posedge clk) disable iff (!rst_n)
                    (step == ST_WBACK && op == OP_LOAD) |-> $past(mem_rd, 2)); // R11

endmodule

// File: tb/bcd_cpu_tb.sv
module bcd_cpu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  logic [7:0]  mem [4096];
  int          cyc = 0;
  int          wr_cnt = 0;
  int          wr_cyc [8];
  logic [15:0] watch_addr = 16'hFFFF;
  logic        seen = 1'b0;
  int          n_chk = 0, n_bad = 0;
  int          wp;

  always #4 clk = ~clk;

  bcd_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // behavioural memory, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= 0;
      wr_cnt <= 0;
      seen   <= 1'b0;
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
      if (mem_rd && mem_addr == watch_addr) seen <= 1'b1;
      if (mem_wr) begin
        mem[mem_addr[11:0]] <= mem_wdata;
        wr_cyc[wr_cnt % 8]  <= cyc;
        wr_cnt              <= wr_cnt + 1;
      end
      cyc <= cyc + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    mem[wp[11:0]] = b;
    wp++;
  endtask

  task automatic prep(input int at);
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    wp = at;
    repeat (2) @(posedge clk);
  endtask

  task automatic go(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int dec(input logic [7:0] v);
    return v[7:4] * 10 + v[3:0];
  endfunction

  function automatic logic [7:0] enc(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b, input logic sub);
    int r;
    if (!sub) begin
      r = dec(a) + dec(b);
      return {r >= 100, enc(r % 100)};
    end
    r = dec(a) - dec(b);
    return {r < 0, enc((r + 100) % 100)};
  endfunction

  // load R0/R1, arithmetic, store result, flag observed via jump-on-carry
  task automatic run_alu(input logic [7:0] a, input logic [7:0] b, input logic sub);
    logic [8:0] exp;
    prep(0);
    mem[12'h100] = a; mem[12'h101] = b; mem[12'h102] = 8'h01;
    emit(8'h00); emit(8'h01); emit(8'h00);
    emit(8'h04); emit(8'h01); emit(8'h01);
    emit(sub ? 8'hA1 : 8'h81);
    emit(8'h20); emit(8'h02); emit(8'h00);
    emit(8'h60); emit(8'h00); emit(8'h10);
    emit(8'h40); emit(8'h00); emit(8'h0D);
    wp = 16'h10;
    emit(8'h08); emit(8'h01); emit(8'h02);
    emit(8'h22); emit(8'h02); emit(8'h01);
    emit(8'h40); emit(8'h00); emit(8'h16);
    go(90);
    exp = model(a, b, sub);
    if (sub) check("R6 difference", mem[12'h200], exp[7:0]);
    else     check("R5 sum", mem[12'h200], exp[7:0]);
    check("R8 flag via jump-on-carry", mem[12'h201], {7'b0, exp[8]});
  endtask

  initial begin
    logic [7:0] ra, rb;
    void'($urandom(32'd20240611));

    // R1 reset state and first fetch
    prep(0);
    emit(8'h40); emit(8'h00); emit(8'h00);
    @(negedge clk);
    check("R1 no write in reset", mem_wr, 0);
    check("R1 pc reset", mem_addr, 16'h0000);
    rst_n = 1'b1;
    #1;
    check("R1 first fetch strobe", mem_rd, 1);
    check("R1 first fetch address", mem_addr, 16'h0000);

    // R5/R6/R8 corner cases
    run_alu(8'h99, 8'h01, 1'b0);
    run_alu(8'h00, 8'h01, 1'b1);
    run_alu(8'h45, 8'h45, 1'b1);
    run_alu(8'h50, 8'h50, 1'b0);
    run_alu(8'h09, 8'h01, 1'b0);
    run_alu(8'h10, 8'h01, 1'b1);

    // R1: reset after a carry-setting run clears flag and registers
    run_alu(8'h99, 8'h99, 1'b0);
    prep(0);
    mem[12'h200] = 8'hAA; mem[12'h201] = 8'h5A;
    emit(8'h60); emit(8'h00); emit(8'h10);
    emit(8'h21); emit(8'h02); emit(8'h01);
    emit(8'h40); emit(8'h00); emit(8'h06);
    wp = 16'h10;
    emit(8'h20); emit(8'h02); emit(8'h00);
    emit(8'h40); emit(8'h00); emit(8'h13);
    go(40);
    check("R1 flag cleared, jump-on-carry not taken", mem[12'h200], 8'hAA);
    check("R1 register cleared", mem[12'h201], 8'h00);

    // R2/R3/R4/R5: other register fields
    prep(0);
    mem[12'h100] = 8'h58; mem[12'h101] = 8'h67;
    emit(8'h08); emit(8'h01); emit(8'h00);
    emit(8'h0C); emit(8'h01); emit(8'h01);
    emit(8'h8B);
    emit(8'h22); emit(8'h02); emit(8'h00);
    emit(8'h23); emit(8'h02); emit(8'h01);
    emit(8'h40); emit(8'h00); emit(8'h0D);
    go(60);
    check("R5 R2+R3 sum into R2", mem[12'h200], 8'h25);
    check("R2 source register unchanged", mem[12'h201], 8'h67);
    check("R4 write count", wr_cnt, 2);

    // R9/R10/R3: load, two unused opcodes, store; timing of write
    prep(0);
    mem[12'h100] = 8'h42;
    emit(8'h00); emit(8'h01); emit(8'h00);
    emit(8'hDF); emit(8'hEE);
    emit(8'h20); emit(8'h02); emit(8'h00);
    emit(8'h40); emit(8'h00); emit(8'h08);
    go(50);
    check("R3/R9 loaded value survives unused opcodes", mem[12'h200], 8'h42);
    check("R10 load+2 unused+store write cycle", wr_cyc[0], 23);

    // R10: unused, add, two stores
    prep(0);
    emit(8'hC0); emit(8'h80);
    emit(8'h20); emit(8'h02); emit(8'h00);
    emit(8'h20); emit(8'h02); emit(8'h01);
    emit(8'h40); emit(8'h00); emit(8'h08);
    go(40);
    check("R10 first store cycle", wr_cyc[0], 15);
    check("R10 second store cycle", wr_cyc[1], 23);

    // R7: jump to an address above 0x7FFF
    prep(0);
    watch_addr = 16'h8123;
    mem[12'h200] = 8'hAA;
    emit(8'h40); emit(8'h81); emit(8'h23);
    wp = 16'h123;
    emit(8'h20); emit(8'h02); emit(8'h00);
    emit(8'h40); emit(8'h81); emit(8'h26);
    go(40);
    check("R7 fetch from jump target", seen, 1);
    check("R7 code at target ran", mem[12'h200], 8'h00);

    // random decimal operands, add and subtract
    for (int k = 0; k < 40; k++) begin
      ra = {4'($urandom % 10), 4'($urandom % 10)};
      rb = {4'($urandom % 10), 4'($urandom % 10)};
      run_alu(ra, rb, 1'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule